// File: doc/BRIEF.md
# Opcode Fetch Sequencer for a Multiplexed Address/Data Bus

This block runs the instruction-fetch machine cycle of a small 8-bit processor whose low address byte and data byte share one set of pins. After a start request it walks through numbered clock states. In the first state it drives the program counter onto the bus: the high byte goes to a dedicated upper address port and the low byte goes to the shared port. It also pulses an address latch enable so that an external latch can hold the low byte. It then releases the shared port, pulls an active-low read strobe, and captures the byte that memory returns into an instruction register.

In the fourth state a decode hint from outside tells the sequencer whether the fetched opcode needs two more internal states. Opcodes that work on 8-bit registers end the cycle at state four. Opcodes that need 16-bit internal work, such as a register-pair increment or moving a pair into the program counter or stack pointer, stretch the cycle to six states. A one-state completion strobe marks the last state. If start is still held at that point, the next fetch begins on the following clock with no idle gap.

Top module: `ofetch_seq`

## Requirements
- R1: While `rst` is high, and on the clock after it, the block is idle. In that state `ale`=0, `ad_oe`=0, `rd_n`=1, `ad_out`=0, `addr_hi`=0, `{io_m,s1,s0}`=3'b000, `done`=0 and `ir`=0, and the program counter returns to `PC_RESET`.
- R2: When `start` is high in the idle state, the next state is state one. In state one `ale`=1, `ad_oe`=1, `ad_out` equals the low byte of the program counter and `addr_hi` equals its high byte.
- R3: From state one to the last state of the cycle `{io_m,s1,s0}` reads 3'b011 (memory, fetch). In idle it reads 3'b000.
- R4: In states two and three `ale`=0, `ad_oe`=0 and `rd_n`=0. In every other state `rd_n`=1, and `ale`/`ad_oe` are high only in state one.
- R5: The byte on `ad_in` is stored in `ir` at the clock edge that ends state three. `ir` shows it from state four on and holds it until the next such edge.
- R6: The program counter goes up by one at that same edge and then holds. `addr_hi` keeps the fetched address's high byte until the next state one.
- R7: In state four, `long_op`=0 ends the cycle at state four with `done`=1. `long_op`=1 adds states five and six, and `done`=1 only in state six.
- R8: In the last state of a cycle, `start`=1 makes the next state state one, with no idle state between. `start`=0 makes the next state idle.
- R9: `start` has no effect in states one, two, three and five, and in state four when `long_op`=1. `long_op` has no effect outside state four.
- R10: The program counter wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a fetch cycle |
| ad_in | input | DW | Byte read from the shared bus |
| long_op | input | 1 | Decode hint sampled in state four; 1 selects the six-state cycle |
| addr_hi | output | AW-DW | Upper address byte |
| ad_out | output | DW | Low address byte driven onto the shared bus |
| ad_oe | output | 1 | Output enable for `ad_out` |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Active-low read strobe |
| io_m | output | 1 | Status: 0 selects memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| ir | output | DW | Instruction register |
| done | output | 1 | High in the last state of the cycle |

## Verification
Two things can land on one clock edge. The end of one fetch (the state-four length decision, or state six) can coincide with the launch of the next state one, and the increment of the program counter at the end of state three feeds the address shown in that state one. The bench runs long chains of back-to-back fetches, with `start` held and `long_op` chosen at random. For each new state one it checks that the address is exactly one above the previous fetch, including across the wrap, and that `ir` still holds the previously captured byte. Between the fetch states `start` and `long_op` are randomised, so any wrong sampling of them would show up as a changed sequence.

// File: rtl/ofetch_pkg.sv
package ofetch_pkg;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_T4   = 3'd4,
    TS_T5   = 3'd5,
    TS_T6   = 3'd6
  } tstate_e;

  // Status code presented for a memory opcode fetch {io_m, s1, s0}
  localparam logic [2:0] STAT_FETCH = 3'b011;
  localparam logic [2:0] STAT_IDLE  = 3'b000;

  function automatic logic in_cycle(tstate_e s);
    return s != TS_IDLE;
  endfunction

  function automatic logic read_phase(tstate_e s);
    return (s == TS_T2) || (s == TS_T3);
  endfunction

endpackage

// File: rtl/ofetch_tseq.sv
module ofetch_tseq
  import ofetch_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    long_op,
  output tstate_e st,
  output tstate_e nxt,
  output logic    done
);

  always_comb begin
    nxt = st;
    case (st)
      TS_IDLE: nxt = start ? TS_T1 : TS_IDLE;
      TS_T1:   nxt = TS_T2;
      TS_T2:   nxt = TS_T3;
      TS_T3:   nxt = TS_T4;
      TS_T4:   nxt = long_op ? TS_T5 : (start ? TS_T1 : TS_IDLE);
      TS_T5:   nxt = TS_T6;
      TS_T6:   nxt = start ? TS_T1 : TS_IDLE;
      default: nxt = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= TS_IDLE;
    else     st <= nxt;
  end

  // Final-state strobe depends on the length hint sampled in state four
  assign done = ((st == TS_T4) && !long_op) || (st == TS_T6);

endmodule

// File: rtl/ofetch_pc.sv
module ofetch_pc #(
  parameter int unsigned         AW       = 16,
  parameter logic [AW-1:0]       PC_RESET = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  output logic [AW-1:0] pc
);

  localparam logic [AW-1:0] ONE = AW'(1);

  always_ff @(posedge clk) begin
    if (rst)      pc <= PC_RESET;
    else if (inc) pc <= pc + ONE;
  end

endmodule

// File: rtl/ofetch_busio.sv
module ofetch_busio
  import ofetch_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  tstate_e          nxt,
  input  logic             capture,
  input  logic [AW-1:0]    pc,
  input  logic [DW-1:0]    ad_in,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  output logic             ale,
  output logic             rd_n,
  output logic [2:0]       status,
  output logic [DW-1:0]    ir
);

  localparam int unsigned HW = AW - DW;

  logic enter_t1;
  assign enter_t1 = (nxt == TS_T1);

  // Outputs are registered from the next state so they line up with it
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_hi <= '0;
      ad_out  <= '0;
      ad_oe   <= 1'b0;
      ale     <= 1'b0;
      rd_n    <= 1'b1;
      status  <= STAT_IDLE;
    end else begin
      ale    <= enter_t1;
      ad_oe  <= enter_t1;
      ad_out <= enter_t1 ? pc[DW-1:0] : '0;
      if (enter_t1) addr_hi <= pc[AW-1:DW];
      rd_n   <= !read_phase(nxt);
      status <= in_cycle(nxt) ? STAT_FETCH : STAT_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ir <= '0;
    else if (capture) ir <= ad_in;
  end

  logic [HW-1:0] unused_hw;
  assign unused_hw = '0;

endmodule

// File: rtl/ofetch_seq.sv
module ofetch_seq
  import ofetch_pkg::*;
#(
  parameter int unsigned   AW       = 16,
  parameter int unsigned   DW       = 8,
  parameter logic [AW-1:0] PC_RESET = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DW-1:0]    ad_in,
  input  logic             long_op,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  output logic             ale,
  output logic             rd_n,
  output logic             io_m,
  output logic             s1,
  output logic             s0,
  output logic [DW-1:0]    ir,
  output logic             done
);

  tstate_e       st;
  tstate_e       nxt;
  logic          capture;
  logic [AW-1:0] pc;
  logic [2:0]    status;

  ofetch_tseq u_tseq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .long_op (long_op),
    .st      (st),
    .nxt     (nxt),
    .done    (done)
  );

  // Byte capture and counter step share the edge that ends state three
  assign capture = (st == TS_T3);

  ofetch_pc #(.AW(AW), .PC_RESET(PC_RESET)) u_pc (
    .clk (clk),
    .rst (rst),
    .inc (capture),
    .pc  (pc)
  );

  ofetch_busio #(.AW(AW), .DW(DW)) u_busio (
    .clk     (clk),
    .rst     (rst),
    .nxt     (nxt),
    .capture (capture),
    .pc      (pc),
    .ad_in   (ad_in),
    .addr_hi (addr_hi),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .ale     (ale),
    .rd_n    (rd_n),
    .status  (status),
    .ir      (ir)
  );

  assign {io_m, s1, s0} = status;

endmodule

// File: rtl/ofetch_seq_chk.sv
module ofetch_seq_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [DW-1:0]    ad_in,
  input logic             long_op,
  input logic [AW-DW-1:0] addr_hi,
  input logic [DW-1:0]    ad_out,
  input logic             ad_oe,
  input logic             ale,
  input logic             rd_n,
  input logic             io_m,
  input logic             s1,
  input logic             s0,
  input logic [DW-1:0]    ir,
  input logic             done
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R2: latch enable lasts exactly one state
  a_r2_ale_single: assert property (@(posedge clk) disable iff (rst || rst_q)
    ale |=> !ale);

  // R3: while the low address is driven the status shows a memory fetch
  a_r3_status_fetch: assert property (@(posedge clk) disable iff (rst || rst_q)
    ad_oe |-> (!io_m && s1 && s0));

  // R4: read strobe falls only in the state after the latch pulse
  a_r4_rd_after_ale: assert property (@(posedge clk) disable iff (rst || rst_q)
    $fell(rd_n) |-> $past(ale));

  // R4: never read while driving the shared bus
  a_r4_no_contention: assert property (@(posedge clk) disable iff (rst || rst_q)
    !(ad_oe && !rd_n));

  // R5: instruction register only changes as the read strobe ends
  a_r5_ir_hold: assert property (@(posedge clk) disable iff (rst || rst_q)
    !$rose(rd_n) |-> $stable(ir));

  // R6: upper address held between latch pulses
  a_r6_hi_hold: assert property (@(posedge clk) disable iff (rst || rst_q)
    !ale |-> $stable(addr_hi));

  // R8: continuation at the last state
  a_r8_chain: assert property (@(posedge clk) disable iff (rst || rst_q)
    (done && start) |=> ale);

  a_r8_to_idle: assert property (@(posedge clk) disable iff (rst || rst_q)
    (done && !start) |=> (!ale && rd_n && !s1 && !s0));

  // R7: completion never overlaps bus activity
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (rst || rst_q)
    done |-> (rd_n && !ad_oe));

  logic [DW-1:0] unused_in;
  assign unused_in = ad_in ^ ad_out ^ {{(DW-1){1'b0}}, long_op};

endmodule

bind ofetch_seq ofetch_seq_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_ofetch_seq.sv
module test_ofetch_seq;

  localparam int unsigned   AW   = 16;
  localparam int unsigned   DW   = 8;
  localparam logic [15:0]   PCR  = 16'hFFFE;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [7:0]    ad_in = '0;
  logic          long_op = 1'b0;
  logic [7:0]    addr_hi;
  logic [7:0]    ad_out;
  logic          ad_oe, ale, rd_n, io_m, s1, s0, done;
  logic [7:0]    ir;

  int checks = 0;
  int fails  = 0;
  logic [15:0] epc = PCR;
  logic [7:0]  eir = '0;

  always #5 clk = ~clk;

  ofetch_seq #(.AW(AW), .DW(DW), .PC_RESET(PCR)) i_ofetch_seq (
    .clk(clk), .rst(rst), .start(start), .ad_in(ad_in), .long_op(long_op),
    .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale),
    .rd_n(rd_n), .io_m(io_m), .s1(s1), .s0(s0), .ir(ir), .done(done)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'hA5;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " ale"}, ale, 1'b0);
    chk({tag, " oe"}, ad_oe, 1'b0);
    chk({tag, " rd_n"}, rd_n, 1'b1);
    chk({tag, " status"}, {io_m, s1, s0}, 3'b000);
    chk({tag, " done"}, done, 1'b0);
  endtask

  // Called at the falling edge inside state one; returns at the falling
  // edge after the last state of the cycle.
  task automatic fetch(input bit lng, input bit keep);
    logic [15:0] a;
    a = epc;
    chk("R2 ale", ale, 1'b1);
    chk("R2 oe", ad_oe, 1'b1);
    chk("R2 ad_out", ad_out, a[7:0]);
    chk("R6 R10 addr_hi", addr_hi, a[15:8]);
    chk("R3 status T1", {io_m, s1, s0}, 3'b011);
    chk("R4 rd_n T1", rd_n, 1'b1);
    chk("R5 ir hold", ir, eir);
    start = 1'($urandom); ad_in = 8'($urandom); long_op = 1'($urandom);
    @(negedge clk);
    chk("R4 T2", {ale, ad_oe, rd_n}, 3'b000);
    chk("R9 R3 status T2", {io_m, s1, s0}, 3'b011);
    ad_in = memf(a); start = 1'($urandom); long_op = 1'($urandom);
    @(negedge clk);
    chk("R4 T3", {ale, ad_oe, rd_n}, 3'b000);
    chk("R5 ir before capture", ir, eir);
    long_op = lng;
    start = lng ? 1'($urandom) : keep;
    @(negedge clk);
    eir = memf(a);
    epc = a + 16'd1;
    chk("R5 ir captured", ir, eir);
    chk("R4 rd_n T4", rd_n, 1'b1);
    chk("R6 addr_hi T4", addr_hi, a[15:8]);
    chk("R7 done T4", done, !lng);
    ad_in = 8'($urandom);
    if (lng) begin
      start = 1'($urandom);
      @(negedge clk);
      long_op = 1'($urandom);
      chk("R7 done T5", done, 1'b0);
      chk("R3 status T5", {io_m, s1, s0}, 3'b011);
      start = 1'($urandom);
      @(negedge clk);
      chk("R7 done T6", done, 1'b1);
      chk("R6 addr_hi T6", addr_hi, a[15:8]);
      start = keep;
    end
    @(negedge clk);
    if (!keep) chk_idle("R8 idle after");
    start = 1'b0;
    if (keep) start = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk_idle("R1 reset");
    chk("R1 ir", ir, 8'h00);
    chk("R1 addr_hi", addr_hi, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1 after reset");
    @(negedge clk);
    chk_idle("R8 stays idle");
    start = 1'b1;
    @(negedge clk);
    fetch(1'b0, 1'b1);
    fetch(1'b1, 1'b1);      // crosses FFFF -> 0000 (R10)
    fetch(1'b1, 1'b0);
    repeat (2) @(negedge clk);
    chk_idle("R8 idle gap");
    for (int i = 0; i < 60; i++) begin
      bit l, k;
      l = 1'($urandom);
      k = 1'($urandom);
      if (start == 1'b0) begin
        start = 1'b1;
        @(negedge clk);
      end
      fetch(l, k);
    end
    // Reset in the middle of a cycle
    start = 1'b1;
    if (!ale) @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk_idle("R1 mid reset");
    chk("R1 ir mid reset", ir, 8'h00);
    rst = 1'b0;
    epc = PCR; eir = '0;
    start = 1'b1;
    @(negedge clk);
    fetch(1'b0, 1'b0);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

endmodule